// File: doc/BRIEF.md
# Interconnect Test Pattern Generator

This block generates the parallel stimulus for a board interconnect test. Every one of `NUM_NETS` nets gets its own serial code word. The block then issues the code words one bit position at a time, as a sequence of parallel vectors. Bit `i` of each vector is the value that net `i` must be driven to in that step. Read down the steps, the sequence gives each net's serial code. Read across one step, it gives the vector that the scan chain loads.

A three-bit mode selects one of five diagnostic codes:
- plain binary counting;
- counting that avoids the all-zeros and all-ones words;
- a true part followed by its complement;
- the same true/complement code with a fixed `0`,`1` prefix, so that opens can be told apart from shorts;
- a walking one.

Each code has its own vector count. A single start pulse launches a sequence. Vectors leave through a valid/ready handshake together with a zero-based step index. A one-cycle done flag marks the end. Loading the vectors into a scan chain and capturing the responses are handled elsewhere.

Definitions used below: W = ceil(log2 NUM_NETS) and M = ceil(log2(NUM_NETS+2)). Serial codes are issued most significant bit first. NUM_NETS must be at least 2.

Top module: `netcode_top`

## Requirements
- R1: After a synchronous active-low reset, `vec_valid`, `done` and `step_idx` are all 0.
- R2: Mode 0 (counting) runs W vectors. Net i's serial code is the W-bit binary value i, and step k carries bit W-1-k of it.
- R3: Mode 1 (modified counting) runs M vectors. Net i's serial code is the M-bit value i+1, so the all-zeros word is never assigned and the all-ones word is assigned only when it is unavoidable.
- R4: Mode 2 (true/complement) runs 2W vectors. Steps 0..W-1 carry net i's W-bit value i, MSB first. Steps W..2W-1 carry the bitwise complement of that value, MSB first.
- R5: Mode 3 (extended true/complement) runs 2W+2 vectors. Step 0 drives every net to 0, step 1 drives every net to 1, and the remaining steps follow the R4 order.
- R6: Mode 4 (walking) runs NUM_NETS vectors. In step k, only net k is driven to 1.
- R7: The step advances only on a cycle where `vec_valid` and `vec_ready` are both high. While `vec_ready` is low, `vec_data` and `step_idx` hold.
- R8: In the cycle after the final handshake, `done` is 1 and `vec_valid` is 0. In the cycle after that, `done` is 0.
- R9: A start pulse that arrives while a sequence is running is ignored. The running sequence keeps its mode and its step.
- R10: A start pulse with a mode code of 5, 6 or 7 is ignored: no vector is issued and `done` stays low.
- R11: `step_idx` gives the zero-based position of the vector currently offered. The first vector is offered, with `step_idx` equal to 0, in the cycle after the start pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a sequence when idle |
| mode | input | 3 | Code scheme select, 0 to 4 |
| vec_ready | input | 1 | Consumer accepts the current vector |
| vec_valid | output | 1 | A vector is offered |
| vec_data | output | NUM_NETS | Parallel vector, bit i drives net i |
| step_idx | output | STEP_W | Zero-based index of the offered vector |
| done | output | 1 | One-cycle pulse after the final vector |

## Verification
The step counter and the latched mode are the only state that shapes the vectors. A fault in either one shows up in the first vector offered after it occurs: a wrong bit column appears in `vec_data`, or `step_idx` disagrees with the number of handshakes counted. A wrong sequence length shows up at the end of the sequence, as `done` arriving too early or too late against the count the requirements give for that mode. A broken stall appears within one cycle of `vec_ready` going low, as a changed vector or index.

// File: rtl/netcode_pkg.sv
// Package: shared mode encoding and helpers for the interconnect pattern generator.
// Assumes callers pass bit positions that may be negative or out of range.
package netcode_pkg;

    typedef enum logic [2:0] {
        MODE_COUNT  = 3'd0,
        MODE_MCOUNT = 3'd1,
        MODE_TC     = 3'd2,
        MODE_XTC    = 3'd3,
        MODE_WALK   = 3'd4
    } code_mode_e;

    // True when the three-bit code names an implemented scheme.
    function automatic logic mode_legal(input logic [2:0] m);
        return m <= 3'd4;
    endfunction

    // Bit 'pos' of an integer code; out-of-range positions read as 0.
    function automatic logic code_bit(input int unsigned code, input int pos);
        logic [31:0] c;
        c = code;
        if (pos < 0 || pos > 31) return 1'b0;
        return c[pos];
    endfunction

endpackage

// File: rtl/netcode_seq.sv
// Module: sequence controller. Accepts a start pulse when idle and latches the mode.
// Steps through the vector count for that mode under valid/ready, then pulses done.
// Assumes the mode is held constant by the user; the latched copy is what counts.
module netcode_seq
    import netcode_pkg::*;
#(
    parameter int NUM_NETS = 10,
    parameter int STEP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode_in,
    input  logic              ready,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output code_mode_e        mode_q,
    output logic              done
);
    localparam int W        = $clog2(NUM_NETS);
    localparam int M        = $clog2(NUM_NETS + 2);
    localparam int LEN_CNT  = W;
    localparam int LEN_MCNT = M;
    localparam int LEN_TC   = 2 * W;
    localparam int LEN_XTC  = 2 * W + 2;
    localparam int LEN_WALK = NUM_NETS;

    logic [STEP_W-1:0] last_step;

    // Purpose: index of the final vector for the latched mode.
    always_comb begin
        case (mode_q)
            MODE_COUNT:  last_step = STEP_W'(LEN_CNT - 1);
            MODE_MCOUNT: last_step = STEP_W'(LEN_MCNT - 1);
            MODE_TC:     last_step = STEP_W'(LEN_TC - 1);
            MODE_XTC:    last_step = STEP_W'(LEN_XTC - 1);
            default:     last_step = STEP_W'(LEN_WALK - 1);
        endcase
    end

    // Purpose: idle/run control, step counting and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            step   <= '0;
            mode_q <= MODE_COUNT;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start && mode_legal(mode_in)) begin
                    busy   <= 1'b1;
                    step   <= '0;
                    mode_q <= code_mode_e'(mode_in);
                end
            end else if (ready) begin
                if (step == last_step) begin
                    busy <= 1'b0;
                    step <= '0;
                    done <= 1'b1;
                end else begin
                    step <= step + 1'b1;
                end
            end
        end
    end

    // R7: a stalled vector keeps its step
    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !ready |=> busy && $stable(step));

    // R8: done is a single-cycle pulse that follows the end of the run
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: start while running leaves the latched mode alone
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(mode_q));

    // R11: the index never passes the final vector of the mode
    assert_step_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> step <= last_step);

endmodule

// File: rtl/netcode_rowgen.sv
// Module: parallel vector builder. For each net it derives that net's code bit
// at the current step from the latched mode. Purely combinational.
// Assumes the step is within the vector count of the mode.
module netcode_rowgen
    import netcode_pkg::*;
#(
    parameter int NUM_NETS = 10,
    parameter int STEP_W   = 4
) (
    input  code_mode_e        mode_q,
    input  logic [STEP_W-1:0] step,
    output logic [NUM_NETS-1:0] row
);
    localparam int W = $clog2(NUM_NETS);
    localparam int M = $clog2(NUM_NETS + 2);

    for (genvar gi = 0; gi < NUM_NETS; gi++) begin : g_net
        localparam int unsigned TRUE_CODE = gi;
        localparam int unsigned MOD_CODE  = gi + 1;

        // Purpose: pick net gi's serial code bit for this step.
        always_comb begin
            int s;
            s = int'(step);
            case (mode_q)
                MODE_COUNT:  row[gi] = code_bit(TRUE_CODE, W - 1 - s);
                MODE_MCOUNT: row[gi] = code_bit(MOD_CODE, M - 1 - s);
                MODE_TC: begin
                    if (s < W) row[gi] = code_bit(TRUE_CODE, W - 1 - s);
                    else       row[gi] = ~code_bit(TRUE_CODE, 2 * W - 1 - s);
                end
                MODE_XTC: begin
                    if (s == 0)          row[gi] = 1'b0;
                    else if (s == 1)     row[gi] = 1'b1;
                    else if (s < W + 2)  row[gi] = code_bit(TRUE_CODE, W + 1 - s);
                    else                 row[gi] = ~code_bit(TRUE_CODE, 2 * W + 1 - s);
                end
                default:     row[gi] = (s == gi);
            endcase
        end
    end

endmodule

// File: rtl/netcode_top.sv
// Module: interconnect test pattern generator top. Connects the controller to the
// vector builder and exposes the valid/ready vector stream.
// Assumes NUM_NETS >= 2 and a mode held constant during a run.
module netcode_top
    import netcode_pkg::*;
#(
    parameter int NUM_NETS = 10,
    localparam int W       = $clog2(NUM_NETS),
    localparam int XLEN    = 2 * W + 2,
    localparam int MAX_LEN = (NUM_NETS > XLEN) ? NUM_NETS : XLEN,
    localparam int STEP_W  = $clog2(MAX_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          mode,
    input  logic                vec_ready,
    output logic                vec_valid,
    output logic [NUM_NETS-1:0] vec_data,
    output logic [STEP_W-1:0]   step_idx,
    output logic                done
);
    code_mode_e mode_q;
    logic       busy;
    logic [NUM_NETS-1:0] row;

    initial begin
        if (NUM_NETS < 2) $error("NUM_NETS must be at least 2");
    end

    netcode_seq #(.NUM_NETS(NUM_NETS), .STEP_W(STEP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
        .ready(vec_ready), .busy(busy), .step(step_idx),
        .mode_q(mode_q), .done(done)
    );

    netcode_rowgen #(.NUM_NETS(NUM_NETS), .STEP_W(STEP_W)) u_row (
        .mode_q(mode_q), .step(step_idx), .row(row)
    );

    // Purpose: drive the stream outputs; data is quiet when nothing is offered.
    always_comb begin
        vec_valid = busy;
        vec_data  = busy ? row : '0;
    end

    // R6: walking vectors carry exactly one 1
    assert_walk_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && mode_q == MODE_WALK |-> $countones(vec_data) == 1);

    // R5: the extension prefix is all 0 then all 1
    assert_xtc_prefix0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && mode_q == MODE_XTC && step_idx == '0 |-> vec_data == '0);
    assert_xtc_prefix1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && mode_q == MODE_XTC && step_idx == STEP_W'(1) |-> &vec_data);

    // R7: a stalled vector stays on the bus unchanged
    assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && !vec_ready |=> vec_valid && $stable(vec_data));

    // R10: an illegal mode code never launches a run
    assert_bad_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid && start && mode > 3'd4 |=> !vec_valid);

endmodule

// File: tb/sim_netcode_top.sv
`timescale 1ns/1ps
module sim_netcode_top;
    localparam int N       = 10;
    localparam int W       = 4;   // ceil(log2 10)
    localparam int M       = 4;   // ceil(log2 12)
    localparam int STEP_W  = 4;   // holds up to 10
    localparam int NCASE   = 6;

    // Table: mode, expected vector count, stall pattern (0 = always ready).
    localparam int CASE_MODE  [NCASE] = '{0, 1, 2, 3, 4, 2};
    localparam int CASE_LEN   [NCASE] = '{4, 4, 8, 10, 10, 8};
    localparam int CASE_STALL [NCASE] = '{0, 1, 2, 3, 0, 4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] mode = 3'd0;
    logic vec_ready = 1'b0;
    logic vec_valid;
    logic [N-1:0] vec_data;
    logic [STEP_W-1:0] step_idx;
    logic done;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    netcode_top #(.NUM_NETS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .vec_ready(vec_ready), .vec_valid(vec_valid), .vec_data(vec_data),
        .step_idx(step_idx), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected bit of net i at step k, built from the whole serial code word.
    function automatic bit exp_bit(input int md, input int i, input int k);
        longint code;
        int len;
        longint mask = (64'd1 << W) - 1;
        case (md)
            0: begin code = i; len = W; end
            1: begin code = i + 1; len = M; end
            2: begin code = (longint'(i) << W) | (~longint'(i) & mask); len = 2 * W; end
            3: begin code = (64'd1 << (2 * W)) | (longint'(i) << W) | (~longint'(i) & mask);
                     len = 2 * W + 2; end
            default: begin code = 64'd1 << (N - 1 - i); len = N; end
        endcase
        return bit'((code >> (len - 1 - k)) & 1);
    endfunction

    function automatic logic [N-1:0] exp_row(input int md, input int k);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = exp_bit(md, i, k);
        return r;
    endfunction

    function automatic string req_of(input int md);
        case (md)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    // One full run; poke >= 0 sends a stray start (walking mode) at that vector (R9).
    task automatic run_case(input int md, input int len, input int stall, input int poke);
        int got = 0;
        int t = 0;
        logic [N-1:0] held_d;
        logic [STEP_W-1:0] held_s;
        bit was_stall = 0;
        @(negedge clk);
        mode = 3'(md); start = 1'b1; vec_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        while (got < len && t < 200) begin
            t++;
            if (was_stall) begin
                check(vec_data == held_d && step_idx == held_s, "R7",
                      {vec_data, step_idx}, {held_d, held_s});
                was_stall = 0;
            end
            check(vec_valid == 1'b1, req_of(md), vec_valid, 1);
            check(step_idx == STEP_W'(got), "R11", step_idx, got);
            check(vec_data == exp_row(md, got), req_of(md), vec_data, exp_row(md, got));
            if (poke == got && t > 0 && !start && was_stall == 0 && vec_ready == 1'b0 && t > 1) begin
                start = 1'b1; mode = 3'd4;
            end
            vec_ready = (stall == 0) ? 1'b1 : ((t % (stall + 1)) == 0);
            if (poke == got) begin
                if (!start) begin start = 1'b1; mode = 3'd4; vec_ready = 1'b0; end
            end
            if (vec_ready) got++;
            else begin
                was_stall = 1; held_d = vec_data; held_s = step_idx;
            end
            @(negedge clk);
            if (start) begin
                start = 1'b0; mode = 3'(md); poke = -1;
                check(step_idx == held_s && vec_valid, "R9", step_idx, held_s);
            end
        end
        vec_ready = 1'b0;
        check(vec_valid == 1'b0 && done == 1'b1, "R8", {vec_valid, done}, 2'b01);
        @(negedge clk);
        check(done == 1'b0, "R8", done, 0);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(vec_valid == 1'b0, "R1", vec_valid, 0);
        check(done == 1'b0, "R1", done, 0);
        check(step_idx == '0, "R1", step_idx, 0);

        for (int c = 0; c < NCASE; c++)
            run_case(CASE_MODE[c], CASE_LEN[c], CASE_STALL[c], -1);

        // R9: stray start mid-run in true/complement mode
        run_case(2, 8, 0, 3);

        // R10: illegal mode codes launch nothing
        for (int bad = 5; bad < 8; bad++) begin
            @(negedge clk);
            mode = 3'(bad); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (2) begin
                check(vec_valid == 1'b0 && done == 1'b0, "R10", {vec_valid, done}, 0);
                @(negedge clk);
            end
        end

        // R1: reset during a run clears the outputs
        run_case(0, 4, 0, -1);
        @(negedge clk);
        mode = 3'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0; vec_ready = 1'b1;
        @(negedge clk);
        rst_n = 1'b0; vec_ready = 1'b0;
        @(negedge clk);
        check(vec_valid == 1'b0 && step_idx == '0 && done == 1'b0, "R1",
              {vec_valid, step_idx, done}, 0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule